// File: doc/BRIEF.md
# Wait-State Register File Slave

This block is a small bank of 32-bit registers on a synchronous memory-mapped bus. A master starts a transfer by raising `read` or `write` together with `address` (and, for a write, `writedata` and `byteenable`) at a rising clock edge. The slave holds `waitrequest` high for a fixed number of wait-state cycles and then drops it. The transfer completes on the first rising edge at which `waitrequest` is low. Reads and writes each have their own wait-state count, set by the parameters `READ_WAIT` and `WRITE_WAIT`. Both kinds of transfer are stretched through the same `waitrequest` output.

The master keeps every bus input constant while `waitrequest` is high. Writes update only the byte lanes that `byteenable` selects. Read data appears on `readdata` only in the cycle in which a read completes. At all other times the output is zero. Addresses beyond the register count read as zero, and writes to them have no effect. A new transfer may begin in the cycle right after the previous one completed, and it then receives its full wait-state count again.

Top module: `ws_regslave`

## Requirements
- R1: After a synchronous reset, every register reads as zero.
- R2: A read holds `waitrequest` high for exactly `READ_WAIT` cycles, counted from the cycle in which `read` first appears. `waitrequest` is low in the next cycle, and `readdata` carries the addressed register in that low cycle.
- R3: A write holds `waitrequest` high for exactly `WRITE_WAIT` cycles, counted from the cycle in which `write` first appears. `waitrequest` is low in the next cycle, and the register takes the new value at the edge that ends that low cycle.
- R4: Bit i of `byteenable` selects byte lane `writedata[8i+7:8i]`. Only the selected lanes of the addressed register change. With `byteenable` = 0000 the register is left unchanged.
- R5: `address` is a word index. Indices at or above `NUM_REGS` read as zero, and a write to such an index changes no register.
- R6: `readdata` is zero in every cycle except the completing cycle of a read, including the wait-state cycles of a read.
- R7: A transfer that starts in the cycle right after another one completed receives its full wait-state count again.
- R8: `waitrequest` is low whenever neither `read` nor `write` is asserted.
- R9: If `read` and `write` are both asserted, the transfer is handled as a write, with the write wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| address | input | ADDR_W | Word index of the register |
| read | input | 1 | Read request |
| write | input | 1 | Write request |
| writedata | input | 32 | Write data |
| byteenable | input | 4 | Lane mask for writes, one bit per byte |
| readdata | output | 32 | Read data, valid only in the completing read cycle |
| waitrequest | output | 1 | High while the slave stalls the current transfer |

## Verification
Two events can fall in the same cycle: a write committing its lanes at one edge, and a read of the same register starting at that same edge with its wait counter restarted. The bench provokes this by issuing write–read and write–write pairs back to back with no idle cycle between them. Against its own lane-merged model, the bench then checks two things: that the following transfer again sees the full stall length, and that it returns the freshly merged word.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int unsigned LANE_W = 8;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_kind_t;

    // Decoded request as seen by the sub-blocks.
    typedef struct packed {
        xfer_kind_t kind;
        logic       mapped;
    } xfer_req_t;

    // Write has priority when both strobes are raised.
    function automatic xfer_kind_t decode_kind(input logic rd, input logic wr);
        if (wr)      return XF_WRITE;
        else if (rd) return XF_READ;
        else         return XF_IDLE;
    endfunction

endpackage

// File: rtl/ws_wait_ctrl.sv
module ws_wait_ctrl
    import ws_pkg::*;
#(
    parameter int unsigned READ_WAIT  = 1,
    parameter int unsigned WRITE_WAIT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  xfer_kind_t kind,
    output logic       stall,
    output logic       finish
);
    localparam int unsigned MAX_WAIT = (READ_WAIT > WRITE_WAIT) ? READ_WAIT : WRITE_WAIT;
    localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 2);

    logic [CNT_W-1:0] waited;
    logic [CNT_W-1:0] limit;
    logic             active;

    always_comb begin
        active = (kind != XF_IDLE);
        limit  = (kind == XF_WRITE) ? CNT_W'(WRITE_WAIT) : CNT_W'(READ_WAIT);
        stall  = active && (waited < limit);
        finish = active && !stall;
    end

    always_ff @(posedge clk) begin
        if (rst)        waited <= '0;
        else if (stall) waited <= waited + 1'b1;
        else            waited <= '0;
    end

    // R8: no stall without a request
    always_comb begin
        if (!rst && !active) begin
            a_r8_idle_no_wait: assert (!stall);
        end
    end

endmodule

// File: rtl/ws_reg_bank.sv
module ws_reg_bank
    import ws_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic [DATA_W/LANE_W-1:0]            lanes,
    output logic [NUM_REGS-1:0][DATA_W-1:0]     regs
);
    localparam int unsigned NUM_LANES = DATA_W / LANE_W;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    regs[r][l*LANE_W +: LANE_W] <= '0;
                else if (we && (idx == IDX_W'(r)) && lanes[l])
                    regs[r][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    // R4/R5: the bank is untouched unless a mapped write completes
    a_r4_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs));

endmodule

// File: rtl/ws_read_mux.sv
module ws_read_mux
    import ws_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = 3
) (
    input  logic                            re,
    input  logic                            mapped,
    input  logic [IDX_W-1:0]                idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    output logic [DATA_W-1:0]               rdata
);
    always_comb begin
        rdata = '0;
        if (re && mapped) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (idx == IDX_W'(i)) rdata = regs[i];
            end
        end
    end

    // R5: unmapped reads give zero
    always_comb begin
        if (!mapped) begin
            a_r5_unmapped_zero: assert (rdata == '0);
        end
    end

endmodule

// File: rtl/ws_regslave.sv
module ws_regslave
    import ws_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned NUM_REGS   = 8,
    parameter int unsigned READ_WAIT  = 1,
    parameter int unsigned WRITE_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] address,
    input  logic              read,
    input  logic              write,
    input  logic [31:0]       writedata,
    input  logic [3:0]        byteenable,
    output logic [31:0]       readdata,
    output logic              waitrequest
);
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    xfer_req_t                      req;
    logic                           finish;
    logic [IDX_W-1:0]               idx;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    always_comb begin
        req.kind   = decode_kind(read, write);
        req.mapped = (32'(address) < NUM_REGS);
        idx        = IDX_W'(address);
    end

    ws_wait_ctrl #(
        .READ_WAIT  (READ_WAIT),
        .WRITE_WAIT (WRITE_WAIT)
    ) u_wait (
        .clk    (clk),
        .rst    (rst),
        .kind   (req.kind),
        .stall  (waitrequest),
        .finish (finish)
    );

    ws_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (finish && (req.kind == XF_WRITE) && req.mapped),
        .idx   (idx),
        .wdata (writedata),
        .lanes (byteenable),
        .regs  (regs)
    );

    ws_read_mux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_rmux (
        .re     (finish && (req.kind == XF_READ)),
        .mapped (req.mapped),
        .idx    (idx),
        .regs   (regs),
        .rdata  (readdata)
    );

    // R6: no data while a read is stalled or absent
    a_r6_quiet_readdata: assert property (@(posedge clk) disable iff (rst)
        (!read || write || waitrequest) |-> (readdata == '0));

    // R7: a write right after a completed write stalls again
    a_r7_restart_wait: assert property (@(posedge clk) disable iff (rst)
        (write && !waitrequest && (WRITE_WAIT > 0)) |=> (!write || waitrequest));

    // R2: a read with a nonzero count starts stalled
    a_r2_read_starts_stalled: assert property (@(posedge clk) disable iff (rst)
        (!read && !write) ##1 (read && !write && (READ_WAIT > 0)) |-> waitrequest);

endmodule

// File: tb/ws_regslave_test.sv
module ws_regslave_test;

    localparam int RW = 1;
    localparam int WW = 2;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  address = '0;
    logic        read = 1'b0;
    logic        write = 1'b0;
    logic [31:0] writedata = '0;
    logic [3:0]  byteenable = '0;
    logic [31:0] readdata;
    logic        waitrequest;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [31:0] model [NR];

    always #2.5 clk = ~clk;

    ws_regslave #(.ADDR_W(4), .NUM_REGS(NR), .READ_WAIT(RW), .WRITE_WAIT(WW)) uut (
        .clk(clk), .rst(rst), .address(address), .read(read), .write(write),
        .writedata(writedata), .byteenable(byteenable),
        .readdata(readdata), .waitrequest(waitrequest)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 32; b++) if (be[b/8]) r[b] = nw[b];
        return r;
    endfunction

    // Called at posedge+1; returns at posedge+1 after completion.
    task automatic xfer(input bit is_wr, input bit is_rd, input logic [3:0] a,
                        input logic [31:0] d, input logic [3:0] be, input string tag,
                        output logic [31:0] got);
        int waits = is_wr ? WW : RW;
        int k = 0;
        address = a; write = is_wr; read = is_rd;
        writedata = d; byteenable = be;
        got = '0;
        forever begin
            #1;
            check({tag, " waitrequest"}, {31'd0, waitrequest}, {31'd0, k < waits});
            if (k >= waits) begin
                got = readdata;
                @(posedge clk); #1;
                if (is_wr && a < NR) model[a] = merge(model[a], d, be);
                break;
            end
            if (is_rd && !is_wr) check({tag, " R6 readdata during wait"}, readdata, 32'd0);
            @(posedge clk); #1;
            k++;
        end
    endtask

    task automatic idle(input string tag);
        read = 0; write = 0;
        #1;
        check({tag, " R8 idle waitrequest"}, {31'd0, waitrequest}, 32'd0);
        check({tag, " R6 idle readdata"}, readdata, 32'd0);
        @(posedge clk); #1;
    endtask

    task automatic rd_check(input logic [3:0] a, input string tag);
        logic [31:0] got;
        xfer(0, 1, a, 32'hdead_beef, 4'hf, tag, got);
        check(tag, got, (a < NR) ? model[a] : 32'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be,
                      input string tag);
        logic [31:0] got;
        xfer(1, 0, a, d, be, tag, got);
    endtask

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(posedge clk); #1;
        idle("R8");
        for (int i = 0; i < NR; i++) begin
            rd_check(4'(i), "R1 reset value");
            idle("R1");
        end
        // full writes then reads
        wr(4'd2, 32'h1122_3344, 4'hf, "R3 write");
        idle("R3");
        rd_check(4'd2, "R2 read back");
        idle("R2");
        wr(4'd7, 32'hcafe_f00d, 4'hf, "R3 write top");
        idle("R3");
        rd_check(4'd7, "R2 read top");
        idle("R2");
        // byte lanes
        wr(4'd2, 32'haabb_ccdd, 4'b0101, "R4 lanes 0101");
        idle("R4");
        rd_check(4'd2, "R4 after 0101");
        idle("R4");
        wr(4'd2, 32'h9988_7766, 4'b1000, "R4 lane 3");
        idle("R4");
        rd_check(4'd2, "R4 after 1000");
        idle("R4");
        wr(4'd2, 32'h0000_0000, 4'b0000, "R4 no lanes");
        idle("R4");
        rd_check(4'd2, "R4 after 0000");
        idle("R4");
        // unmapped
        wr(4'd12, 32'hffff_ffff, 4'hf, "R5 unmapped write");
        idle("R5");
        rd_check(4'd12, "R5 unmapped read");
        idle("R5");
        for (int i = 0; i < NR; i++) begin
            rd_check(4'(i), "R5 bank unchanged");
            idle("R5");
        end
        // back to back
        wr(4'd3, 32'h0bad_cafe, 4'hf, "R7 b2b write");
        rd_check(4'd3, "R7 b2b read after write");
        wr(4'd3, 32'h1234_5678, 4'b0011, "R7 b2b write after read");
        wr(4'd3, 32'hffff_ffff, 4'b1100, "R7 b2b write after write");
        rd_check(4'd3, "R7 b2b final read");
        rd_check(4'd2, "R7 b2b read after read");
        idle("R7");
        // both strobes: write wins
        begin
            logic [31:0] got;
            xfer(1, 1, 4'd5, 32'h5555_aaaa, 4'hf, "R9 both strobes", got);
            check("R9 readdata when both", got, 32'd0);
        end
        idle("R9");
        rd_check(4'd5, "R9 write took effect");
        idle("R9");
        // reset clears
        rst = 1; @(posedge clk); #1; rst = 0;
        for (int i = 0; i < NR; i++) model[i] = '0;
        rd_check(4'd3, "R1 cleared by reset");
        idle("R1");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule